// File: doc/BRIEF.md
# 1-Wire ROM Search Enumerator

This block walks the binary tree of 64-bit device identifiers present on a 1-Wire bus and reports each identifier once. It sits above a bit-level bus master and drives that master through three commands: a bus reset with presence sampling, a byte write, and a search triplet (read bit, read complement, write the chosen direction). A single `start` pulse launches a complete enumeration; the block then runs as many search passes as the tree requires.

Every pass opens with a bus reset, sends the search command byte, and issues one triplet per identifier bit, least significant bit first. The direction sent with each triplet follows a discrepancy rule, so that each pass resolves one more fork of the tree. Forks where the zero branch is taken are tracked so that the next pass can flip the deepest one. After each full pass the found identifier is presented with a one-cycle valid strobe, together with its low byte as the family code. A one-cycle `done` pulse marks the end of the enumeration: when the last device has been reported, when no device answers the reset, or when a triplet reports that neither branch exists.

Top module: `rom_search_enum`

## Requirements
- R1: After reset `busy`, `cmd_valid`, `id_valid` and `done` are low and `id_out` is zero; with `busy` low no command is issued.
- R2: Every pass starts with a reset command (`cmd_op` = 0). If the response has `rsp_presence` low, `done` pulses in the cycle after that response, no byte is written and no identifier is reported.
- R3: After a reset that sees a presence, one write-byte command (`cmd_op` = 1) with `cmd_byte` = 8'hF0 is issued, then exactly ID_W triplet commands (`cmd_op` = 2) for bit positions 0 upward, before the identifier is reported. Each command is a one-cycle `cmd_valid` pulse and the next is issued only after `rsp_valid`.
- R4: The triplet direction `cmd_dir` for bit i is 1 when i equals the current fork position, 0 when i is above it, and otherwise bit i of the identifier found in the previous pass; the fork position starts at ID_W and the previous identifier starts at zero, so identifiers are reported in ascending order of their bit-reversed value.
- R5: Bit 2 of each triplet response (`rsp_trip[2]`) is the bit stored at position i of the identifier being assembled.
- R6: A triplet response whose bits 1 and 0 are both 1 ends the enumeration: `done` pulses in the following cycle and the partial identifier is not reported.
- R7: A response of exactly 3'b000 records i as the deepest zero fork of the pass (cleared at each pass start). After a pass the enumeration ends if no zero fork was recorded or the recorded fork equals the current fork position; otherwise the fork position takes the recorded value and a new pass starts. Hence every device is reported exactly once and `done` follows the last report.
- R8: `id_family` equals bits 7:0 of `id_out`.
- R9: `id_out` changes only in a cycle where `id_valid` is high and keeps its value after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin an enumeration; taken only when idle |
| busy | output | 1 | High while an enumeration runs |
| cmd_valid | output | 1 | One-cycle command strobe to the bit-level master |
| cmd_op | output | 2 | Command: 0 reset, 1 write byte, 2 triplet |
| cmd_byte | output | 8 | Byte for a write-byte command |
| cmd_dir | output | 1 | Direction written by a triplet when both branches exist |
| rsp_valid | input | 1 | One-cycle completion strobe from the master |
| rsp_presence | input | 1 | Reset result: 1 when a device answered |
| rsp_trip | input | 3 | Triplet result: bit 0 id bit, bit 1 complement bit, bit 2 taken direction |
| id_valid | output | 1 | One-cycle strobe for a found identifier |
| id_out | output | ID_W | Last found identifier |
| id_family | output | 8 | Family code, low byte of `id_out` |
| done | output | 1 | One-cycle end-of-enumeration pulse |

## Verification
A command leaves one cycle after the block decides on it, and a response is acted on at the clock edge that samples `rsp_valid`, so `done` after a failed presence or a triplet abort is due exactly one cycle after the response, and `id_valid` one cycle after the last triplet response. The bench sweeps every subset of a pool of six identifiers through a bus model that answers triplets as a wired-AND bus would, and compares each strobe against the subset sorted by bit-reversed value. All outputs are sampled on the falling edge, half a cycle after the edge that changes them, and the presence and abort corner cases are confirmed by the checker's one-cycle properties.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WBYTE = 2'd1,
        OP_TRIP  = 2'd2
    } rs_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_GO,
        ST_RST_WAIT,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_TRI_GO,
        ST_TRI_WAIT,
        ST_EMIT,
        ST_FIN
    } rs_state_e;

    // triplet response: taken direction, complement bit, id bit
    typedef struct packed {
        logic taken;
        logic comp;
        logic idb;
    } rs_trip_s;

    localparam logic [7:0] SEARCH_CMD = 8'hF0;

    function automatic logic trip_abort(rs_trip_s t);
        return t.comp & t.idb;
    endfunction

    function automatic logic trip_zero_fork(rs_trip_s t);
        return (t == 3'b000);
    endfunction

endpackage

// File: rtl/rs_branch.sv
module rs_branch #(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6,
    parameter int POS_W = 7
) (
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [POS_W-1:0] fork_pos,
    input  logic [ID_W-1:0]  prev_id,
    output logic             dir
);

    logic [POS_W-1:0] idx_ext;

    always_comb begin
        idx_ext = POS_W'(bit_idx);
        if (idx_ext == fork_pos) begin
            dir = 1'b1;
        end else if (idx_ext > fork_pos) begin
            dir = 1'b0;
        end else begin
            dir = prev_id[bit_idx];
        end
    end

endmodule

// File: rtl/rs_track.sv
module rs_track #(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6,
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_run,
    input  logic             clr_pass,
    input  logic             bit_we,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             zero_fork,
    input  logic             last_bit,
    input  logic             adopt,
    output logic [POS_W-1:0] fork_pos,
    output logic [IDX_W-1:0] lz_pos,
    output logic             lz_valid,
    output logic [ID_W-1:0]  prev_id,
    output logic [ID_W-1:0]  id_out
);

    logic [ID_W-1:0] work_id;
    logic [ID_W-1:0] next_id;

    always_comb begin
        next_id = work_id;
        next_id[bit_idx] = bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fork_pos <= POS_W'(ID_W);
            lz_pos   <= '0;
            lz_valid <= 1'b0;
            prev_id  <= '0;
            work_id  <= '0;
            id_out   <= '0;
        end else begin
            if (clr_run) begin
                fork_pos <= POS_W'(ID_W);
                prev_id  <= '0;
                lz_valid <= 1'b0;
            end
            if (clr_pass) begin
                lz_valid <= 1'b0;
                work_id  <= '0;
            end
            if (bit_we) begin
                work_id <= next_id;
                if (zero_fork) begin
                    lz_pos   <= bit_idx;
                    lz_valid <= 1'b1;
                end
                if (last_bit) begin
                    id_out  <= next_id;
                    prev_id <= next_id;
                end
            end
            if (adopt) begin
                fork_pos <= POS_W'(lz_pos);
            end
        end
    end

endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import rs_pkg::*;
#(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6,
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rsp_valid,
    input  logic             rsp_presence,
    input  rs_trip_s         rsp_trip,
    input  logic             lz_valid,
    input  logic [IDX_W-1:0] lz_pos,
    input  logic [POS_W-1:0] fork_pos,
    output logic             busy,
    output logic             cmd_valid,
    output rs_op_e           cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             id_valid,
    output logic             done,
    output logic             clr_run,
    output logic             clr_pass,
    output logic             bit_we,
    output logic             zero_fork,
    output logic             last_bit,
    output logic             adopt,
    output logic [IDX_W-1:0] bit_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

    rs_state_e state;
    logic      abort;
    logic      finish;

    assign abort     = trip_abort(rsp_trip);
    assign zero_fork = trip_zero_fork(rsp_trip);
    assign last_bit  = (bit_idx == LAST_IDX);
    assign finish    = !lz_valid || (POS_W'(lz_pos) == fork_pos);

    assign clr_run  = (state == ST_IDLE) && start;
    assign clr_pass = (state == ST_RST_WAIT) && rsp_valid && rsp_presence;
    assign bit_we   = (state == ST_TRI_WAIT) && rsp_valid && !abort;
    assign adopt    = (state == ST_EMIT) && !finish;

    assign busy      = (state != ST_IDLE);
    assign cmd_valid = (state == ST_RST_GO) || (state == ST_CMD_GO) || (state == ST_TRI_GO);
    assign cmd_byte  = (state == ST_CMD_GO) ? SEARCH_CMD : 8'h00;
    assign id_valid  = (state == ST_EMIT);
    assign done      = (state == ST_FIN);

    always_comb begin
        case (state)
            ST_CMD_GO: cmd_op = OP_WBYTE;
            ST_TRI_GO: cmd_op = OP_TRIP;
            default:   cmd_op = OP_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE:     if (start) state <= ST_RST_GO;
                ST_RST_GO:   state <= ST_RST_WAIT;
                ST_RST_WAIT: if (rsp_valid) state <= rsp_presence ? ST_CMD_GO : ST_FIN;
                ST_CMD_GO:   state <= ST_CMD_WAIT;
                ST_CMD_WAIT: begin
                    if (rsp_valid) begin
                        state   <= ST_TRI_GO;
                        bit_idx <= '0;
                    end
                end
                ST_TRI_GO:   state <= ST_TRI_WAIT;
                ST_TRI_WAIT: begin
                    if (rsp_valid) begin
                        if (abort) begin
                            state <= ST_FIN;
                        end else if (last_bit) begin
                            state <= ST_EMIT;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_TRI_GO;
                        end
                    end
                end
                ST_EMIT:     state <= finish ? ST_FIN : ST_RST_GO;
                ST_FIN:      state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rom_search_enum.sv
module rom_search_enum
    import rs_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic            cmd_valid,
    output logic [1:0]      cmd_op,
    output logic [7:0]      cmd_byte,
    output logic            cmd_dir,
    input  logic            rsp_valid,
    input  logic            rsp_presence,
    input  logic [2:0]      rsp_trip,
    output logic            id_valid,
    output logic [ID_W-1:0] id_out,
    output logic [7:0]      id_family,
    output logic            done
);

    localparam int IDX_W = $clog2(ID_W);
    localparam int POS_W = IDX_W + 1;

    rs_trip_s         trip;
    rs_op_e           op;
    logic [POS_W-1:0] fork_pos;
    logic [IDX_W-1:0] lz_pos;
    logic             lz_valid;
    logic [ID_W-1:0]  prev_id;
    logic [IDX_W-1:0] bit_idx;
    logic             clr_run, clr_pass, bit_we, zero_fork, last_bit, adopt;
    logic             dir;

    assign trip      = rs_trip_s'(rsp_trip);
    assign cmd_op    = op;
    assign cmd_dir   = cmd_valid && (op == OP_TRIP) && dir;
    assign id_family = id_out[7:0];

    rs_seq #(.ID_W(ID_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .rsp_valid(rsp_valid), .rsp_presence(rsp_presence), .rsp_trip(trip),
        .lz_valid(lz_valid), .lz_pos(lz_pos), .fork_pos(fork_pos),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_op(op), .cmd_byte(cmd_byte),
        .id_valid(id_valid), .done(done),
        .clr_run(clr_run), .clr_pass(clr_pass), .bit_we(bit_we),
        .zero_fork(zero_fork), .last_bit(last_bit), .adopt(adopt),
        .bit_idx(bit_idx)
    );

    rs_track #(.ID_W(ID_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_track (
        .clk(clk), .rst(rst),
        .clr_run(clr_run), .clr_pass(clr_pass), .bit_we(bit_we),
        .bit_idx(bit_idx), .bit_val(trip.taken), .zero_fork(zero_fork),
        .last_bit(last_bit), .adopt(adopt),
        .fork_pos(fork_pos), .lz_pos(lz_pos), .lz_valid(lz_valid),
        .prev_id(prev_id), .id_out(id_out)
    );

    rs_branch #(.ID_W(ID_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_branch (
        .bit_idx(bit_idx), .fork_pos(fork_pos), .prev_id(prev_id), .dir(dir)
    );

endmodule

// File: rtl/rom_search_enum_chk.sv
module rom_search_enum_chk #(
    parameter int ID_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic [7:0]      cmd_byte,
    input logic            rsp_valid,
    input logic            rsp_presence,
    input logic [2:0]      rsp_trip,
    input logic            id_valid,
    input logic [ID_W-1:0] id_out,
    input logic            done
);

    logic [1:0] last_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op <= 2'd0;
        end else if (cmd_valid) begin
            last_op <= cmd_op;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_valid && !id_valid));

    assert_no_presence_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_op == 2'd0 && !rsp_presence) |=> (done && !id_valid));

    assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_search_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1) |-> (cmd_byte == 8'hF0));

    assert_abort_end_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_op == 2'd2 && rsp_trip[1:0] == 2'b11) |=> (done && !id_valid));

    assert_id_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> $stable(id_out));

endmodule

bind rom_search_enum rom_search_enum_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_presence(rsp_presence),
    .rsp_trip(rsp_trip), .id_valid(id_valid), .id_out(id_out), .done(done)
);

// File: tb/rom_search_enum_tb.sv
`timescale 1ns/1ps
module rom_search_enum_tb;

    localparam int ID_W  = 64;
    localparam int NPOOL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, cmd_valid, cmd_dir, id_valid, done;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte, id_family;
    logic rsp_valid = 1'b0;
    logic rsp_presence = 1'b0;
    logic [2:0] rsp_trip = 3'b000;
    logic [ID_W-1:0] id_out;

    always #4 clk = ~clk;

    rom_search_enum #(.ID_W(ID_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_dir(cmd_dir),
        .rsp_valid(rsp_valid), .rsp_presence(rsp_presence), .rsp_trip(rsp_trip),
        .id_valid(id_valid), .id_out(id_out), .id_family(id_family), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [ID_W-1:0] pool [NPOOL];
    logic [ID_W-1:0] exp_ids [NPOOL];
    int exp_n = 0;
    logic [NPOOL-1:0] sel = '0;
    logic inj_err = 1'b0;

    // bus model state
    logic [NPOOL-1:0] active = '0;
    logic [NPOOL-1:0] act_n;
    int tri_idx = 0;
    int wb_count = 0;
    int wb_bad = 0;
    logic pend = 1'b0;
    int cnt = 0;
    logic [1:0] pend_op = 2'd0;
    logic pend_dir = 1'b0;
    logic idb, cmb, ch;

    // monitor state
    int k = 0;
    logic run_done = 1'b0;
    logic [ID_W-1:0] last_id = '0;

    function automatic logic [ID_W-1:0] rev_bits(logic [ID_W-1:0] v);
        logic [ID_W-1:0] r;
        for (int i = 0; i < ID_W; i++) r[i] = v[ID_W-1-i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [ID_W-1:0] act,
                         input logic [ID_W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // bit-level master model: wired-AND bus with selected devices
    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (cnt == 0) begin
                pend <= 1'b0;
                rsp_valid <= 1'b1;
                case (pend_op)
                    2'd0: begin
                        active <= sel;
                        rsp_presence <= |sel;
                        tri_idx <= 0;
                    end
                    2'd2: begin
                        idb = 1'b1;
                        cmb = 1'b1;
                        for (int d = 0; d < NPOOL; d++) begin
                            if (active[d]) begin
                                if (pool[d][tri_idx] == 1'b0) idb = 1'b0;
                                else cmb = 1'b0;
                            end
                        end
                        if (inj_err && tri_idx == 5) begin
                            idb = 1'b1;
                            cmb = 1'b1;
                        end
                        if (idb && cmb) begin
                            rsp_trip <= 3'b011;
                            ch = 1'b0;
                        end else if (!idb && !cmb) begin
                            ch = pend_dir;
                            rsp_trip <= {pend_dir, 2'b00};
                        end else begin
                            ch = idb;
                            rsp_trip <= idb ? 3'b101 : 3'b010;
                        end
                        act_n = active;
                        for (int d = 0; d < NPOOL; d++)
                            if (pool[d][tri_idx] != ch) act_n[d] = 1'b0;
                        active <= act_n;
                        tri_idx <= tri_idx + 1;
                    end
                    default: ;
                endcase
            end else begin
                cnt <= cnt - 1;
            end
        end else if (cmd_valid) begin
            pend <= 1'b1;
            cnt <= 1;
            pend_op <= cmd_op;
            pend_dir <= cmd_dir;
            if (cmd_op == 2'd1) begin
                wb_count <= wb_count + 1;
                if (cmd_byte != 8'hF0) wb_bad <= wb_bad + 1;
            end
        end
    end

    // output monitor, half a cycle after the changing edge
    always @(negedge clk) begin
        if (!rst && id_valid) begin
            if (k < exp_n) begin
                check(id_out == exp_ids[k], "R4/R5 id order and bits", id_out, exp_ids[k]);
            end else begin
                check(1'b0, "R7 extra id reported", id_out, '0);
            end
            check(id_family == id_out[7:0], "R8 family code", ID_W'(id_family), ID_W'(id_out[7:0]));
            check(tri_idx == ID_W, "R3 triplets per pass", ID_W'(tri_idx), ID_W'(ID_W));
            k++;
            last_id = id_out;
        end
        if (!rst && done) run_done = 1'b1;
    end

    task automatic run(input logic [NPOOL-1:0] m, input logic err);
        logic [ID_W-1:0] tmp;
        sel = m;
        inj_err = err;
        exp_n = 0;
        for (int d = 0; d < NPOOL; d++)
            if (m[d]) begin
                exp_ids[exp_n] = pool[d];
                exp_n++;
            end
        for (int a = 0; a < exp_n; a++)
            for (int b = a + 1; b < exp_n; b++)
                if (rev_bits(exp_ids[b]) < rev_bits(exp_ids[a])) begin
                    tmp = exp_ids[a];
                    exp_ids[a] = exp_ids[b];
                    exp_ids[b] = tmp;
                end
        if (err) exp_n = 0;
        k = 0;
        wb_count = 0;
        wb_bad = 0;
        run_done = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!run_done) @(negedge clk);
        if (err) begin
            check(k == 0, "R6 abort reports nothing", ID_W'(k), '0);
        end else begin
            check(k == $countones(m), "R7 device count", ID_W'(k), ID_W'($countones(m)));
        end
        check(id_out == last_id, "R9 id held after done", id_out, last_id);
        check(wb_bad == 0, "R3 search byte", ID_W'(wb_bad), '0);
        if (m == '0) begin
            check(wb_count == 0, "R2 no write without presence", ID_W'(wb_count), '0);
        end
        @(negedge clk);
        check(!busy, "R2 idle after done", ID_W'(busy), '0);
    endtask

    initial begin
        pool[0] = 64'h1234_5678_9ABC_DE28;
        pool[1] = 64'h1234_5678_9ABC_DE29;
        pool[2] = 64'hA5A5_0000_0000_0028;
        pool[3] = 64'h0000_0000_0000_0001;
        pool[4] = 64'hFFFF_FFFF_FFFF_FFFF;
        pool[5] = 64'h8000_0000_0000_0028;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !cmd_valid && !id_valid && !done, "R1 reset outputs quiet",
              ID_W'({busy, cmd_valid, id_valid, done}), '0);
        check(id_out == '0, "R1 reset id", id_out, '0);
        repeat (4) @(negedge clk);
        check(!cmd_valid, "R1 no command while idle", ID_W'(cmd_valid), '0);
        for (int m = 0; m < (1 << NPOOL); m++) run(NPOOL'(m), 1'b0);
        run('1, 1'b1);
        run(6'b000001, 1'b1);
        run(6'b110011, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule